// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits between the asynchronous interrupt pins of a chip and the CPU's interrupt logic. It takes one non-maskable interrupt pin and eight maskable interrupt pins. It synchronizes each pin and turns the NMI pin into a one-cycle delivery strobe. The eight maskable pins form two groups of four, and each group produces either an encoded interrupt level or four separate request flags.

A small control register sets the behaviour. It selects which NMI edge counts. It selects whether a detected NMI waits while the CPU reports that it is blocking exceptions, or is delivered at once. It also selects the mode of each pin group. When an NMI is delivered while the CPU is blocking, a warning strobe fires together with the delivery strobe, because the CPU's saved exception state is then overwritten. Software writes the whole register word in one cycle and can read back the four control bits at any time.

Top module: `ext_irq_front`

## Requirements
- R1: After reset the control register reads 0, `nmi_take` and `nmi_overrun` are 0, and with all pins high `grp_level` and `grp_req` are 0.
- R2: With bit 24 clear, a falling edge on `nmi_pin` raises `nmi_take` in the third rising clock edge after the pin changes (two synchronizer flops, then one output register).
- R3: With bit 24 set, only a rising edge on `nmi_pin` is detected, and a falling edge produces no `nmi_take`.
- R4: With bit 25 clear, a detected NMI stays pending while `cpu_block` is 1 and gives no `nmi_take`. It is delivered on the first rising edge at which `cpu_block` is 0.
- R5: With bit 25 set, a detected NMI is delivered even while `cpu_block` is 1, and `nmi_overrun` is 1 in the same cycle as `nmi_take` exactly when `cpu_block` was 1 at delivery.
- R6: Further NMI edges that arrive while an NMI is already pending merge into it, so only one `nmi_take` results.
- R7: A group in encoded mode (its mode bit 0) drives its 4-bit `grp_level` field with the inverted synchronized pins. All pins high gives level 0, meaning no request. Its `grp_req` bits are 0.
- R8: A group in independent mode (its mode bit 1) reports each low pin as a 1 in the matching `grp_req` bit. Its `grp_level` field is 0.
- R9: Bit 23 sets the mode of `irq_pin[3:0]` (fields `[3:0]`). Bit 22 sets the mode of `irq_pin[7:4]` (fields `[7:4]`). The two groups switch independently.
- R10: Bits 25..22 of the control register are writable and readable through `cfg_rdata`. All other bits read as 0.
- R11: Changing the NMI edge polarity while the pin is steady produces no `nmi_take`.
- R12: `nmi_take` is a single-cycle pulse for each delivered NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_pin | input | 8 | Asynchronous active-low interrupt pins, two groups of four |
| cpu_block | input | 1 | CPU exception-block state |
| nmi_take | output | 1 | One-cycle NMI delivery strobe |
| nmi_overrun | output | 1 | Strobe: NMI delivered while `cpu_block` was 1 |
| grp_level | output | 8 | Encoded level per group, 4 bits each |
| grp_req | output | 8 | Independent request flags per pin |

## Verification
The bench holds an NMI through a long block and then releases it. A design that ignored the hold would strobe too early, and one that lost the pending state would never strobe. It sends two falling edges during one block to catch a design that counts them twice. It also flips the edge polarity on a steady pin, where a careless detector would create a spurious delivery. The groups are set to mixed modes with asymmetric pin patterns, which exposes swapped mode bits, a level that is not inverted, and a mode that leaks into the other output.

// File: rtl/ext_irq_pkg.sv
// Package: shared bit positions and sizes for the external interrupt front end.
// Assumes a 32-bit control word; only the four mode bits below are implemented.
package ext_irq_pkg;
    localparam int CFG_W          = 32;
    localparam int NMI_NOHOLD_BIT = 25;
    localparam int NMI_RISE_BIT   = 24;
    localparam int GRP0_MODE_BIT  = 23;  // group g uses GRP0_MODE_BIT - g
    localparam int GRP_W          = 4;
    localparam int NUM_GRP        = 2;
    localparam int PIN_W          = GRP_W * NUM_GRP;
    localparam logic [CFG_W-1:0] CFG_MASK =
        (CFG_W'(1) << NMI_NOHOLD_BIT) | (CFG_W'(1) << NMI_RISE_BIT) |
        (CFG_W'(1) << GRP0_MODE_BIT)  | (CFG_W'(1) << (GRP0_MODE_BIT - 1));
endpackage

// File: rtl/irq_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is implied.
module irq_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages that bring the pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/nmi_edge_ctrl.sv
// Module: NMI edge detection, pending hold and delivery.
// Assumes pin_s is already synchronized. A detected edge is delivered on the
// next clock when allowed; otherwise it waits in a single pending flag that
// absorbs later edges.
module nmi_edge_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic rise_i,
    input  logic nohold_i,
    input  logic blk_i,
    input  logic pol_wr_i,
    output logic take_o,
    output logic overrun_o
);
    logic prev_q;
    logic pend_q;
    logic edge_hit;
    logic req;
    logic fire;

    // Edge in the selected direction, masked in the cycle the polarity changes.
    always_comb begin
        edge_hit = rise_i ? (pin_s & ~prev_q) : (~pin_s & prev_q);
        if (pol_wr_i) edge_hit = 1'b0;
        req  = pend_q | edge_hit;
        fire = req & (~blk_i | nohold_i);
    end

    // Previous-sample register, pending flag and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b1;
            pend_q    <= 1'b0;
            take_o    <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            prev_q    <= pin_s;
            pend_q    <= req & ~fire;
            take_o    <= fire;
            overrun_o <= fire & blk_i;
        end
    end

    a_r12_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    a_r5_overrun_with_take: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> take_o);
    a_r4_no_take_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(!blk_i || nohold_i));
endmodule

// File: rtl/irq_pin_group.sv
// Module: one group of active-low interrupt pins, encoded or independent.
// Assumes synchronized inputs; the outputs follow the pins without a register.
module irq_pin_group #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic         indep_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] req_o
);
    // Route the inverted pins to the output that the mode selects.
    always_comb begin
        level_o = indep_i ? '0 : ~pins_s;
        req_o   = indep_i ? ~pins_s : '0;
    end

    a_r7_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|level_o) && (|req_o)));
endmodule

// File: rtl/ext_irq_front.sv
// Module: top of the external interrupt front end. It holds the control
// register, synchronizes all pins and instantiates the NMI path and one
// conditioner per pin group. Assumes a single clock and whole-word writes.
module ext_irq_front
    import ext_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             nmi_pin,
    input  logic [PIN_W-1:0] irq_pin,
    input  logic             cpu_block,
    output logic             nmi_take,
    output logic             nmi_overrun,
    output logic [PIN_W-1:0] grp_level,
    output logic [PIN_W-1:0] grp_req
);
    logic [CFG_W-1:0] cfg_q;
    logic             nmi_s;
    logic [PIN_W-1:0] irq_s;
    logic             pol_wr;

    // Control register: only the implemented bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata & CFG_MASK;
    end

    // Read port and detection of a write that flips the NMI polarity.
    always_comb begin
        cfg_rdata = cfg_q;
        pol_wr    = cfg_we & (cfg_wdata[NMI_RISE_BIT] != cfg_q[NMI_RISE_BIT]);
    end

    irq_sync2 #(.W(1), .RST_VAL(1'b1)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d_i(nmi_pin), .q_o(nmi_s));

    irq_sync2 #(.W(PIN_W), .RST_VAL('1)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d_i(irq_pin), .q_o(irq_s));

    nmi_edge_ctrl u_nmi (
        .clk(clk), .rst_n(rst_n), .pin_s(nmi_s),
        .rise_i(cfg_q[NMI_RISE_BIT]), .nohold_i(cfg_q[NMI_NOHOLD_BIT]),
        .blk_i(cpu_block), .pol_wr_i(pol_wr),
        .take_o(nmi_take), .overrun_o(nmi_overrun));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_pin_group #(.W(GRP_W)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .pins_s(irq_s[g*GRP_W +: GRP_W]),
            .indep_i(cfg_q[GRP0_MODE_BIT - g]),
            .level_o(grp_level[g*GRP_W +: GRP_W]),
            .req_o(grp_req[g*GRP_W +: GRP_W]));
    end

    a_r10_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CFG_MASK) == '0);
endmodule

// File: tb/ext_irq_front_test.sv
module ext_irq_front_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        nmi_pin = 1;
    logic [7:0]  irq_pin = 8'hFF;
    logic        cpu_block = 0;
    logic        nmi_take, nmi_overrun;
    logic [7:0]  grp_level, grp_req;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_front uut (.*);

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        cfg_we = 1; cfg_wdata = v;
        step(1);
        cfg_we = 0;
    endtask

    task automatic t_reset;
        check("R1 cfg", cfg_rdata, 0);
        check("R1 take", nmi_take, 0);
        check("R1 overrun", nmi_overrun, 0);
        check("R1 level", grp_level, 0);
        check("R1 req", grp_req, 0);
    endtask

    task automatic t_cfg;
        write_cfg(32'hFFFF_FFFF);
        check("R10 readback", cfg_rdata, 32'h03C0_0000);
        write_cfg(32'h0);
        check("R10 cleared", cfg_rdata, 0);
        step(3);
    endtask

    task automatic t_fall;
        nmi_pin = 0;
        step(2); check("R2 not yet", nmi_take, 0);
        step(1); check("R2 take", nmi_take, 1);
        step(1); check("R12 single pulse", nmi_take, 0);
        nmi_pin = 1;
        for (int i = 0; i < 4; i++) begin step(1); check("R2 rising ignored", nmi_take, 0); end
    endtask

    task automatic t_rise;
        write_cfg(32'h0100_0000);
        for (int i = 0; i < 4; i++) begin step(1); check("R11 no spurious", nmi_take, 0); end
        nmi_pin = 0;
        for (int i = 0; i < 5; i++) begin step(1); check("R3 falling ignored", nmi_take, 0); end
        nmi_pin = 1;
        step(3); check("R3 rising take", nmi_take, 1);
        step(1); check("R12 rise pulse", nmi_take, 0);
        write_cfg(32'h0);
        for (int i = 0; i < 4; i++) begin step(1); check("R11 back to falling", nmi_take, 0); end
    endtask

    task automatic t_hold;
        cpu_block = 1;
        nmi_pin = 0;
        for (int i = 0; i < 6; i++) begin step(1); check("R4 held", nmi_take, 0); end
        cpu_block = 0;
        step(1); check("R4 released", nmi_take, 1);
        check("R5 no overrun", nmi_overrun, 0);
        step(1); check("R12 after hold", nmi_take, 0);
        nmi_pin = 1; step(4);
    endtask

    task automatic t_merge;
        int takes = 0;
        cpu_block = 1;
        nmi_pin = 0; step(3);
        nmi_pin = 1; step(3);
        nmi_pin = 0; step(3);
        check("R6 held during merge", nmi_take, 0);
        cpu_block = 0;
        for (int i = 0; i < 6; i++) begin step(1); takes += nmi_take; end
        check("R6 single delivery", takes, 1);
        nmi_pin = 1; step(4);
    endtask

    task automatic t_nohold;
        write_cfg(32'h0200_0000);
        cpu_block = 1;
        nmi_pin = 0;
        step(3); check("R5 take while blocked", nmi_take, 1);
        check("R5 overrun", nmi_overrun, 1);
        step(1); check("R5 overrun clears", nmi_overrun, 0);
        nmi_pin = 1; cpu_block = 0; step(4);
        nmi_pin = 0;
        step(3); check("R5 take unblocked", nmi_take, 1);
        check("R5 no overrun unblocked", nmi_overrun, 0);
        nmi_pin = 1; step(4);
        write_cfg(32'h0);
    endtask

    task automatic t_enc;
        irq_pin = 8'hA5;
        step(2); check("R7 level", grp_level, 8'h5A);
        check("R7 req zero", grp_req, 0);
        irq_pin = 8'hFF;
        step(2); check("R7 idle", grp_level, 0);
    endtask

    task automatic t_ind;
        irq_pin = 8'h3C;
        write_cfg(32'h0080_0000);
        step(2);
        check("R9 grp0 req", grp_req, 8'h03);
        check("R9 grp1 level", grp_level, 8'hC0);
        write_cfg(32'h0040_0000);
        check("R9 grp1 req", grp_req, 8'hC0);
        check("R9 grp0 level", grp_level, 8'h03);
        write_cfg(32'h00C0_0000);
        check("R8 req", grp_req, 8'hC3);
        check("R8 level zero", grp_level, 0);
        irq_pin = 8'hFF;
        step(2); check("R8 idle", grp_req, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_cfg();
        t_fall();
        t_rise();
        t_hold();
        t_merge();
        t_nohold();
        t_enc();
        t_ind();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule